// File: doc/BRIEF.md
# Operand Wordlength Reduction Multiplier

This block multiplies two signed two's-complement operands after passing each one through its own wordlength reducer. Narrowing the operands this way cuts switching activity in the multiplier array. Each reducer is set by a two-bit mode and a shift amount N. It can pass the word through unchanged. It can clear the N least significant bits, which keeps the top W−N bits including the sign. It can also shift the word right by N positions with sign fill.

The two reduced words feed a radix-4 modified Booth core. A swap control picks which of the two words is Booth-recoded and which one acts as the multiplicand. The product value does not depend on the swap. Only the switching behaviour of the array changes.

A valid/ready pair at the input and another at the output carry operands in and products out. The product is held in a register. Each operand port also has a counter that accumulates the bit transitions between successive accepted reduced operands. The counters give a direct measure of how much activity a chosen reduction saves.

Top module: `wlr_mult`

## Requirements
- R1: One cycle after an accepted input, `product` holds the exact 2W-bit signed product of the two reduced operands.
- R2: With mode 2'b01 (clear-low), the reduced operand is the input with its N least significant bits forced to zero and its upper W−N bits kept.
- R3: With mode 2'b10 (sign shift), the reduced operand is the input shifted right arithmetically by N, so the vacated top bits repeat the input sign bit.
- R4: Mode 2'b00 (pass) and the reserved mode 2'b11 leave the operand unchanged for any N. N = 0 in mode 2'b01 or 2'b10 also leaves it unchanged.
- R5: `swap` = 0 Booth-recodes operand A and `swap` = 1 Booth-recodes operand B. The product is identical for both settings.
- R6: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An input is accepted when `in_valid` and `in_ready` are both high at a clock edge, and `out_valid` is high in the following cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `product` is stable and no new input is accepted.
- R8: On each accepted input, each toggle counter adds the number of bit positions in which that port's reduced operand differs from the previous accepted reduced operand of the same port. The previous value is zero after reset. Without an accepted input the counters hold.
- R9: After reset, `out_valid`, `product` and both toggle counters are zero.
- R10: An 8-bit reduction is supported both as clear-low with N = 8, which keeps the upper byte, and as a sign shift with N = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Block can accept an input this cycle |
| opa | input | W (16) | Operand A, two's complement |
| opb | input | W (16) | Operand B, two's complement |
| mode_a | input | 2 | Reduction mode for A (00 pass, 01 clear-low, 10 sign shift, 11 pass) |
| amt_a | input | log2(W) (4) | Reduction amount N for A |
| mode_b | input | 2 | Reduction mode for B |
| amt_b | input | log2(W) (4) | Reduction amount N for B |
| swap | input | 1 | 0: A is Booth-recoded, 1: B is Booth-recoded |
| out_valid | output | 1 | Product register holds an undelivered result |
| out_ready | input | 1 | Consumer takes the product |
| product | output | 2W (32) | Signed product of the reduced operands |
| toggles_a | output | CW (32) | Accumulated bit transitions on reduced A |
| toggles_b | output | CW (32) | Accumulated bit transitions on reduced B |

## Verification
The bench builds the block with its defaults: W = 16 and 32-bit counters. With these values the 4-bit amount field covers every shift from 0 to 15, and all eight Booth digits, including the most negative operand value, are exercised. Random operands, modes, amounts and swap settings are mixed with directed cases: 8-bit reductions, N = 0, the reserved mode, both swap settings on the same pair, and an output stall with a competing input.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
  typedef enum logic [1:0] {
    RED_PASS  = 2'b00,
    RED_CLEAR = 2'b01,
    RED_SHIFT = 2'b10,
    RED_RSVD  = 2'b11
  } red_mode_e;
endpackage

// File: rtl/wlr_reduce.sv
module wlr_reduce
  import wlr_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] keep_mask;

  assign keep_mask = {W{1'b1}} << amt;

  always_comb begin
    case (red_mode_e'(mode))
      RED_CLEAR: dout = din & keep_mask;
      RED_SHIFT: dout = $signed(din) >>> amt;
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/wlr_booth.sv
module wlr_booth #(
  parameter int W = 16
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam int ND = W / 2;

  logic [PW-1:0] xe;
  logic [PW-1:0] pps [ND];

  assign xe = {{W{mcand[W-1]}}, mcand};

  genvar i;
  generate
    for (i = 0; i < ND; i++) begin : g_dig
      logic [2:0]    grp;
      logic [PW-1:0] pp;
      if (i == 0) begin : g_lo
        assign grp = {mplier[1], mplier[0], 1'b0};
      end else begin : g_hi
        assign grp = mplier[2*i+1 -: 3];
      end
      always_comb begin
        case (grp)
          3'b001, 3'b010: pp = xe;
          3'b011:         pp = xe << 1;
          3'b100:         pp = -(xe << 1);
          3'b101, 3'b110: pp = -xe;
          default:        pp = '0;
        endcase
      end
      assign pps[i] = pp << (2 * i);
    end
  endgenerate

  always_comb begin
    prod = '0;
    for (int k = 0; k < ND; k++) prod = prod + pps[k];
  end
endmodule

// File: rtl/wlr_toggle.sv
module wlr_toggle #(
  parameter int W  = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  logic [W-1:0] prev;

  function automatic logic [CW-1:0] ones(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int k = 0; k < W; k++) n = n + CW'(v[k]);
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      count <= '0;
    end else if (en) begin
      prev  <= din;
      count <= count + ones(din ^ prev);
    end
  end
endmodule

// File: rtl/wlr_mult.sv
module wlr_mult
  import wlr_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 32,
  localparam int AW = $clog2(W),
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [1:0]    mode_a,
  input  logic [AW-1:0] amt_a,
  input  logic [1:0]    mode_b,
  input  logic [AW-1:0] amt_b,
  input  logic          swap,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] product,
  output logic [CW-1:0] toggles_a,
  output logic [CW-1:0] toggles_b
);
  logic          accept;
  logic [W-1:0]  red_a, red_b, mcand, mplier;
  logic [PW-1:0] core_prod;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  wlr_reduce #(.W(W), .AW(AW)) i_red_a (.din(opa), .mode(mode_a), .amt(amt_a), .dout(red_a));
  wlr_reduce #(.W(W), .AW(AW)) i_red_b (.din(opb), .mode(mode_b), .amt(amt_b), .dout(red_b));

  assign mplier = swap ? red_b : red_a;
  assign mcand  = swap ? red_a : red_b;

  wlr_booth #(.W(W)) i_core (.mcand(mcand), .mplier(mplier), .prod(core_prod));

  wlr_toggle #(.W(W), .CW(CW)) i_tog_a (.clk(clk), .rst(rst), .en(accept), .din(red_a), .count(toggles_a));
  wlr_toggle #(.W(W), .CW(CW)) i_tog_b (.clk(clk), .rst(rst), .en(accept), .din(red_b), .count(toggles_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      product   <= core_prod;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  logic signed [PW-1:0] ref_prod;
  assign ref_prod = $signed(red_a) * $signed(red_b);

  assert_exact_product_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> product == $past(ref_prod));
  assert_shift_sign_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_a == RED_SHIFT) |-> red_a[W-1] == opa[W-1]);
  assert_valid_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(product)));
  assert_counters_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(toggles_a) && $stable(toggles_b)));
endmodule

// File: tb/test_wlr_mult.sv
module test_wlr_mult;
  localparam int W  = 16;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, out_ready = 1'b1, swap = 1'b0;
  logic [W-1:0]  opa = '0, opb = '0;
  logic [1:0]    mode_a = 2'b00, mode_b = 2'b00;
  logic [3:0]    amt_a = '0, amt_b = '0;
  logic          in_ready, out_valid;
  logic [2*W-1:0] product;
  logic [CW-1:0] toggles_a, toggles_b;

  int total = 0, bad = 0;
  logic [W-1:0]  prev_a = '0, prev_b = '0;
  logic [CW-1:0] exp_ta = '0, exp_tb = '0;

  always #4 clk = ~clk;

  wlr_mult #(.W(W), .CW(CW)) i_wlr_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .mode_a(mode_a), .amt_a(amt_a),
    .mode_b(mode_b), .amt_b(amt_b), .swap(swap),
    .out_valid(out_valid), .out_ready(out_ready), .product(product),
    .toggles_a(toggles_a), .toggles_b(toggles_b));

  function automatic logic [W-1:0] model_reduce(logic [W-1:0] x, logic [1:0] m, logic [3:0] n);
    logic [W-1:0] r;
    r = x;
    if (m == 2'b01) for (int k = 0; k < W; k++) if (k < n) r[k] = 1'b0;
    if (m == 2'b10) for (int k = 0; k < W; k++) r[k] = (k + n < W) ? x[k + n] : x[W-1];
    return r;
  endfunction

  function automatic logic [2*W-1:0] model_mul(logic [W-1:0] a, logic [W-1:0] b);
    longint pa, pb;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    return (2*W)'(pa * pb);
  endfunction

  function automatic logic [CW-1:0] model_dist(logic [W-1:0] a, logic [W-1:0] b);
    logic [CW-1:0] c;
    c = '0;
    for (int k = 0; k < W; k++) if (a[k] != b[k]) c = c + 1;
    return c;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(string req, logic [W-1:0] a, logic [W-1:0] b, logic [1:0] ma, logic [3:0] na,
                     logic [1:0] mb, logic [3:0] nb, logic sw);
    logic [W-1:0] ra, rb;
    opa = a; opb = b; mode_a = ma; amt_a = na; mode_b = mb; amt_b = nb; swap = sw;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ra = model_reduce(a, ma, na);
    rb = model_reduce(b, mb, nb);
    exp_ta = exp_ta + model_dist(ra, prev_a);
    exp_tb = exp_tb + model_dist(rb, prev_b);
    prev_a = ra; prev_b = rb;
    check({req, " product"}, 64'(product), 64'(model_mul(ra, rb)));
    check("R6 out_valid", 64'(out_valid), 64'd1);
    check("R8 toggles_a", 64'(toggles_a), 64'(exp_ta));
    check("R8 toggles_b", 64'(toggles_b), 64'(exp_tb));
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2*W-1:0] held;
    logic [CW-1:0]  ta_hold;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 product", 64'(product), 64'd0);
    check("R9 toggles_a", 64'(toggles_a), 64'd0);
    check("R9 toggles_b", 64'(toggles_b), 64'd0);
    check("R6 in_ready idle", 64'(in_ready), 64'd1);

    // R1 pass mode, R4 reserved mode and N=0
    txn("R1", 16'h1234, 16'hDCA9, 2'b00, 4'd0, 2'b00, 4'd0, 1'b0);
    txn("R4 reserved", 16'h8001, 16'h7FFF, 2'b11, 4'd9, 2'b00, 4'd12, 1'b0);
    txn("R4 n0", 16'hBEEF, 16'h4321, 2'b01, 4'd0, 2'b10, 4'd0, 1'b1);
    // R10 / R2 / R3 8-bit reductions
    txn("R10 R2 clear8", 16'h1234, 16'hDCA9, 2'b01, 4'd8, 2'b01, 4'd8, 1'b0);
    txn("R10 R3 shift8", 16'h1234, 16'hDCA9, 2'b10, 4'd8, 2'b10, 4'd8, 1'b0);
    txn("R3 shift15", 16'h8000, 16'h7FFF, 2'b10, 4'd15, 2'b10, 4'd15, 1'b1);
    txn("R2 clear15", 16'h8000, 16'hFFFF, 2'b01, 4'd15, 2'b01, 4'd1, 1'b0);
    // R5 same pair with both swap settings, including most negative value
    txn("R5 swap0", 16'h8000, 16'h8000, 2'b00, 4'd0, 2'b00, 4'd0, 1'b0);
    txn("R5 swap1", 16'h8000, 16'h8000, 2'b00, 4'd0, 2'b00, 4'd0, 1'b1);
    txn("R5 swap0 b", 16'hA5C3, 16'h3C5A, 2'b10, 4'd3, 2'b01, 4'd5, 1'b0);
    txn("R5 swap1 b", 16'hA5C3, 16'h3C5A, 2'b10, 4'd3, 2'b01, 4'd5, 1'b1);

    // R1 random mix
    for (int t = 0; t < 400; t++) begin
      txn("R1 random", W'($urandom), W'($urandom), 2'($urandom), 4'($urandom),
          2'($urandom), 4'($urandom), 1'($urandom));
    end

    // R7 stall: drain, then hold out_ready low
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 drained", 64'(out_valid), 64'd0);
    out_ready = 1'b0;
    txn("R7 stalled txn", 16'h7FFF, 16'h7FFF, 2'b00, 4'd0, 2'b00, 4'd0, 1'b0);
    held = product;
    ta_hold = toggles_a;
    opa = 16'h0001; opb = 16'h0002;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R7 in_ready low", 64'(in_ready), 64'd0);
      check("R7 out_valid held", 64'(out_valid), 64'd1);
      check("R7 product stable", 64'(product), 64'(held));
      check("R7 R8 no count", 64'(toggles_a), 64'(ta_hold));
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 released", 64'(out_valid), 64'd0);
    check("R7 product kept", 64'(product), 64'(held));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule